// File: doc/BRIEF.md
# Pipelined Block-Transfer Slot Sequencer

This block decides, one bus slot at a time, which channel of a block-transfer engine owns the memory bus. The engine has up to three source read channels (A, B, C) and one destination write channel (D). A 4-bit enable code selects the channels. A word count sets the transfer length. A start strobe launches the transfer, and a slot-advance strobe consumes the current slot. For every slot the block reports the owning channel, or idle, together with the index of the word being moved.

The shift, mask and logic datapath behind the bus is a two-stage pipeline. Each destination word is therefore written one word late, in a fixed slot of the following word's group. Every enable combination has its own group length, idle-slot placement and closing tail. The sequence is not a rotation over the enabled channels. After the final slot is consumed, the block raises a one-cycle completion pulse.

An external arbiter may withhold the advance strobe to stall the sequence. The sequence keeps its position while stalled.

Top module: `blt_slot_seq`

## Requirements
- R1: Bit 3 of `enable_i` enables channel A, bit 2 enables B, bit 1 enables C and bit 0 enables D.
  - `chan_o` encodes idle=0, A=1, B=2, C=3, D=4.
  - Each word group opens with its enabled sources in the order A, B, C, and those slots carry the group's word index.
  - Idle slots report word 0.
- R2: With all four channels enabled (code 0xF), a transfer of N words runs as follows:
  - groups of A B C plus one slot;
  - that slot is idle in group 0 and carries D(g-1) in group g;
  - then a single closing D(N-1).
- R3: For codes that have D plus at least one source, D(n) is issued only inside group n+1, at a fixed position:
  - ABD and ACD: group length 3, D at position 2.
  - AD and CD: length 2, D at position 1.
  - BCD: length 4, D at position 3.
  - BD: length 3, D at position 1.
  - Other group slots are idle.
- R4: After the last group of a lagged-destination code there is a tail. The tail is a single D(N-1) for codes 0xF and 0x5. For the other such codes it is one idle slot followed by D(N-1).
- R5: Codes without D pad each group with idle slots, and the last group carries no padding:
  - ABC and AC: no pad.
  - AB, A and C: one idle per group.
  - BC: one idle per group.
  - B: two idles per group.
- R6: Code 0x1 issues D(n) followed by one idle slot per word, with no idle after the last D. Code 0x0 issues N idle slots.
- R7: While busy with `advance_i` low, `chan_o`, `word_o` and `busy_o` hold their values.
- R8: A start while busy is ignored. A word count of 0 is treated as 1.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final slot is consumed. `busy_o` is low in that same cycle.
- R10: After reset, `busy_o` and `done_o` are low and `chan_o` is idle (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a transfer (taken only when idle) |
| enable_i | input | 4 | Channel enable code A,B,C,D from bit 3 down |
| words_i | input | WORD_W | Number of words to move |
| advance_i | input | 1 | Consume the current slot |
| busy_o | output | 1 | A transfer is in progress |
| chan_o | output | 3 | Channel owning the current slot |
| word_o | output | WORD_W | Word index of the current slot |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong group counter or slot index shows up at the ports in the next consumed slot, either as the wrong channel or as a destination word index that differs by one. Each consumed slot is compared at once against an independent template model, so a fault is reported within one advance. A wrong phase or length decode changes the total slot count, and this appears as a missing or early completion pulse at the end of the transfer. Random stalls confirm that position is held across cycles with no advance.

// File: rtl/blt_slot_pkg.sv
package blt_slot_pkg;

   typedef enum logic [2:0] {
      CH_IDLE = 3'd0,
      CH_A    = 3'd1,
      CH_B    = 3'd2,
      CH_C    = 3'd3,
      CH_D    = 3'd4
   } chan_e;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_GRP  = 2'd1,
      PH_TAIL = 2'd2
   } phase_e;

   // Per-code slot profile
   typedef struct packed {
      chan_e      src0;
      chan_e      src1;
      chan_e      src2;
      logic [1:0] nsrc;      // leading slots that carry sources
      logic [2:0] glen;      // full group length
      logic [1:0] dpos;      // slot of the lagged destination
      logic       lag;       // destination trails by one word
      logic [1:0] tail_idle; // idles before the closing destination
   } prof_t;

   function automatic prof_t decode_prof(input logic [3:0] code);
      prof_t p;
      chan_e s [0:2];
      int    n;
      s[0] = CH_IDLE;
      s[1] = CH_IDLE;
      s[2] = CH_IDLE;
      n    = 0;
      if (code[3]) begin s[n] = CH_A; n++; end
      if (code[2]) begin s[n] = CH_B; n++; end
      if (code[1]) begin s[n] = CH_C; n++; end
      p.lag       = code[0] && (n > 0);
      p.dpos      = 2'd0;
      p.tail_idle = 2'd0;
      p.glen      = 3'd1;
      case (code)
         4'hF: begin p.glen = 3'd4; p.dpos = 2'd3; p.tail_idle = 2'd0; end
         4'hD, 4'hB: begin p.glen = 3'd3; p.dpos = 2'd2; p.tail_idle = 2'd1; end
         4'h9, 4'h3: begin p.glen = 3'd2; p.dpos = 2'd1; p.tail_idle = 2'd1; end
         4'h7: begin p.glen = 3'd4; p.dpos = 2'd3; p.tail_idle = 2'd1; end
         4'h5: begin p.glen = 3'd3; p.dpos = 2'd1; p.tail_idle = 2'd0; end
         4'hE, 4'hC, 4'h6, 4'h4: p.glen = 3'd3;
         4'hA, 4'h8, 4'h2: p.glen = 3'd2;
         4'h1: begin s[0] = CH_D; n = 1; p.glen = 3'd2; end
         default: begin s[0] = CH_IDLE; n = 1; p.glen = 3'd1; end
      endcase
      p.src0 = s[0];
      p.src1 = s[1];
      p.src2 = s[2];
      p.nsrc = 2'(n);
      return p;
   endfunction

endpackage

// File: rtl/blt_slot_walker.sv
module blt_slot_walker
   import blt_slot_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              advance,
   input  prof_t             prof,
   input  logic [WORD_W-1:0] last,
   output phase_e            phase,
   output logic [WORD_W-1:0] grp,
   output logic [1:0]        slot,
   output logic              done
);

   logic [2:0] cur_len;
   logic       grp_end;
   logic       last_grp;

   assign last_grp = (grp == last);
   assign cur_len  = (last_grp && !prof.lag) ? {1'b0, prof.nsrc} : prof.glen;
   assign grp_end  = ({1'b0, slot} == (cur_len - 3'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_OFF;
         grp   <= '0;
         slot  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_OFF: begin
               if (start) begin
                  phase <= PH_GRP;
                  grp   <= '0;
                  slot  <= '0;
               end
            end
            PH_GRP: begin
               if (advance) begin
                  if (grp_end) begin
                     slot <= '0;
                     if (last_grp) begin
                        if (prof.lag) begin
                           phase <= PH_TAIL;
                        end else begin
                           phase <= PH_OFF;
                           done  <= 1'b1;
                        end
                     end else begin
                        grp <= grp + 1'b1;
                     end
                  end else begin
                     slot <= slot + 2'd1;
                  end
               end
            end
            PH_TAIL: begin
               if (advance) begin
                  if (slot == prof.tail_idle) begin
                     phase <= PH_OFF;
                     done  <= 1'b1;
                     slot  <= '0;
                  end else begin
                     slot <= slot + 2'd1;
                  end
               end
            end
            default: phase <= PH_OFF;
         endcase
      end
   end

endmodule

// File: rtl/blt_slot_map.sv
module blt_slot_map
   import blt_slot_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  phase_e            phase,
   input  logic [WORD_W-1:0] grp,
   input  logic [1:0]        slot,
   input  prof_t             prof,
   input  logic [WORD_W-1:0] last,
   output chan_e             chan,
   output logic [WORD_W-1:0] word
);

   chan_e             pick;
   logic [WORD_W-1:0] idx;

   always_comb begin
      pick = CH_IDLE;
      idx  = '0;
      case (phase)
         PH_GRP: begin
            if (slot < prof.nsrc) begin
               case (slot)
                  2'd0:    pick = prof.src0;
                  2'd1:    pick = prof.src1;
                  default: pick = prof.src2;
               endcase
               idx = grp;
            end else if (prof.lag && (slot == prof.dpos) && (grp != '0)) begin
               pick = CH_D;
               idx  = grp - 1'b1;
            end
         end
         PH_TAIL: begin
            if (slot == prof.tail_idle) begin
               pick = CH_D;
               idx  = last;
            end
         end
         default: pick = CH_IDLE;
      endcase
      chan = pick;
      word = (pick == CH_IDLE) ? '0 : idx;
   end

endmodule

// File: rtl/blt_slot_seq.sv
module blt_slot_seq
   import blt_slot_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [3:0]        enable_i,
   input  logic [WORD_W-1:0] words_i,
   input  logic              advance_i,
   output logic              busy_o,
   output logic [2:0]        chan_o,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);

   generate
      if (WORD_W < 1 || WORD_W > 24) begin : g_bad_width
         $error("blt_slot_seq: WORD_W out of range");
      end
   endgenerate

   logic [3:0]        code_q;
   logic [WORD_W-1:0] last_q;
   prof_t             prof;
   phase_e            phase;
   logic [WORD_W-1:0] grp;
   logic [1:0]        slot;
   chan_e             chan;
   logic              busy;

   assign busy = (phase != PH_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         last_q <= '0;
      end else if (start_i && !busy) begin
         code_q <= enable_i;
         last_q <= (words_i == '0) ? '0 : words_i - 1'b1;
      end
   end

   assign prof = decode_prof(code_q);

   blt_slot_walker #(.WORD_W(WORD_W)) walk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .advance (advance_i),
      .prof    (prof),
      .last    (last_q),
      .phase   (phase),
      .grp     (grp),
      .slot    (slot),
      .done    (done_o)
   );

   blt_slot_map #(.WORD_W(WORD_W)) map_i (
      .phase (phase),
      .grp   (grp),
      .slot  (slot),
      .prof  (prof),
      .last  (last_q),
      .chan  (chan),
      .word  (word_o)
   );

   assign chan_o = chan;
   assign busy_o = busy;

endmodule

// File: rtl/blt_slot_seq_chk.sv
module blt_slot_seq_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              advance_i,
   input logic              busy_o,
   input logic [2:0]        chan_o,
   input logic [WORD_W-1:0] word_o,
   input logic              done_o
);

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !advance_i) |=> (busy_o && $stable(chan_o) && $stable(word_o)));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o) && $past(advance_i)));

   a_r10_idle_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (chan_o == 3'd0));

   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !advance_i) |=> busy_o);

   a_r1_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
      chan_o <= 3'd4);

endmodule

bind blt_slot_seq blt_slot_seq_chk #(.WORD_W(WORD_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .advance_i (advance_i),
   .busy_o    (busy_o),
   .chan_o    (chan_o),
   .word_o    (word_o),
   .done_o    (done_o)
);

// File: tb/blt_slot_seq_tb_top.sv
module blt_slot_seq_tb_top;

   localparam int WW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [3:0]    enable_i = '0;
   logic [WW-1:0] words_i = '0;
   logic          advance_i = 1'b0;
   logic          busy_o;
   logic [2:0]    chan_o;
   logic [WW-1:0] word_o;
   logic          done_o;

   int checks = 0;
   int errors = 0;

   logic [WW+2:0] exp_q [$];
   string         tag_q [$];

   always #2 clk = ~clk;   // 250 MHz

   blt_slot_seq #(.WORD_W(WW)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .enable_i  (enable_i),
      .words_i   (words_i),
      .advance_i (advance_i),
      .busy_o    (busy_o),
      .chan_o    (chan_o),
      .word_o    (word_o),
      .done_o    (done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Group template per code: letters are sources, 'd' lagged destination, '-' idle
   function automatic string tmpl_of(input logic [3:0] c);
      case (c)
         4'hF: return "ABCd";
         4'hE: return "ABC";
         4'hD: return "ABd";
         4'hC: return "AB-";
         4'hB: return "ACd";
         4'hA: return "AC";
         4'h9: return "Ad";
         4'h8: return "A-";
         4'h7: return "BC-d";
         4'h6: return "BC-";
         4'h5: return "Bd-";
         4'h4: return "B--";
         4'h3: return "Cd";
         4'h2: return "C-";
         4'h1: return "D-";
         default: return "-";
      endcase
   endfunction

   function automatic string tail_of(input logic [3:0] c);
      case (c)
         4'hF, 4'h5: return "D";
         4'hD, 4'hB, 4'h9, 4'h7, 4'h3: return "-D";
         default: return "";
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] c);
      if (c == 4'hF) return "R2";
      if (c == 4'h1 || c == 4'h0) return "R6";
      if (c[0]) return "R3";
      return "R5";
   endfunction

   task automatic push(input int ch, input int w, input string t);
      logic [WW+2:0] item;
      item = {3'(ch), WW'(w)};
      exp_q.push_back(item);
      tag_q.push_back(t);
   endtask

   task automatic build(input logic [3:0] c, input int n);
      string tp;
      string tl;
      int    len;
      tp = tmpl_of(c);
      tl = tail_of(c);
      for (int g = 0; g < n; g++) begin
         len = tp.len();
         if (g == n - 1 && tl.len() == 0 && c != 4'h0)
            while (len > 1 && tp[len-1] == "-") len--;
         for (int i = 0; i < len; i++) begin
            if (tp[i] == "A") push(1, g, tag_of(c));
            else if (tp[i] == "B") push(2, g, tag_of(c));
            else if (tp[i] == "C") push(3, g, tag_of(c));
            else if (tp[i] == "D") push(4, g, tag_of(c));
            else if (tp[i] == "d" && g > 0) push(4, g - 1, tag_of(c));
            else push(0, 0, tag_of(c));
         end
      end
      for (int i = 0; i < tl.len(); i++) begin
         if (tl[i] == "D") push(4, n - 1, "R4");
         else push(0, 0, "R4");
      end
   endtask

   // Driver: push expectations, launch, feed advance until the queue drains
   task automatic run_xfer(input logic [3:0] c, input int n, input bit stall, input bit poke);
      int it;
      build(c, (n == 0) ? 1 : n);
      @(negedge clk);
      enable_i  = c;
      words_i   = WW'(n);
      start_i   = 1'b1;
      advance_i = 1'b0;
      @(negedge clk);
      start_i  = 1'b0;
      enable_i = ~c;
      words_i  = WW'(7);
      it = 0;
      forever begin
         if (exp_q.size() == 0) break;
         advance_i = stall ? (($urandom % 3) != 0) : 1'b1;
         if (poke && it == 2) start_i = 1'b1;   // R8: start while busy
         else start_i = 1'b0;
         it++;
         @(negedge clk);
      end
      start_i   = 1'b0;
      advance_i = 1'b0;
      #1;
      chk(done_o === 1'b1 && busy_o === 1'b0, "R9 done", int'(done_o), 1);
      @(negedge clk);
      #1;
      chk(done_o === 1'b0, "R9 single", int'(done_o), 0);
   endtask

   // Monitor: compare each consumed slot; also confirm stall holding
   bit            held = 1'b0;
   logic [WW+2:0] held_v;
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (held && busy_o) begin
            chk({chan_o, word_o} === held_v, "R7 hold", int'({chan_o, word_o}), int'(held_v));
         end
         held = 1'b0;
         if (busy_o && advance_i) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1 extra slot", int'({chan_o, word_o}), -1);
            end else begin
               logic [WW+2:0] e;
               string         t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({chan_o, word_o} === e, {t, " R1 slot"}, int'({chan_o, word_o}), int'(e));
            end
         end else if (busy_o) begin
            held   = 1'b1;
            held_v = {chan_o, word_o};
         end
      end
   end

   task automatic main();
      int ns [4] = '{1, 2, 3, 5};
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk(busy_o === 1'b0 && done_o === 1'b0 && chan_o === 3'd0, "R10 reset",
          int'({busy_o, done_o, chan_o}), 0);
      rst_n = 1'b1;
      for (int c = 15; c >= 0; c--) begin
         foreach (ns[k]) run_xfer(4'(c), ns[k], 1'b0, 1'b0);
      end
      for (int c = 0; c < 16; c++) run_xfer(4'(c), 3, 1'b1, 1'b0);   // R7 stalls
      run_xfer(4'hF, 4, 1'b0, 1'b1);    // R8 start while busy
      run_xfer(4'h7, 2, 1'b1, 1'b1);    // R8 start while busy, stalled
      run_xfer(4'hF, 0, 1'b0, 1'b0);    // R8 zero words acts as one
      run_xfer(4'h5, 0, 1'b1, 1'b0);    // R8 zero words acts as one
   endtask

   initial begin
      fork
         main();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule